// File: doc/BRIEF.md
# Byte-Lane Bit Manipulation Unit

This unit executes one opcode value of a vector execution pipe. Three operations share that value. Two further fields select among them: a one-bit U qualifier and a two-bit size field. The operations are a population count per byte, a complement of the whole operand, and a reversal of bit order inside each byte. For the count and the reversal, the size field is part of the operation selector and not an element width. Both always work on bytes. The complement treats the operand as plain 64-bit chunks.

An issue slot presents a 128-bit source, the decode fields, a width bit and a valid strobe. One clock later the unit returns either a result with a valid flag or an undefined-encoding flag. The undefined flag covers a foreign opcode and any unallocated U/size pairing. When it is raised, the result register keeps its previous contents. With the width bit low, only the lower 64 bits are produced and the upper half reads zero.

Top module: `simd_bytemisc_unit`

## Requirements
- R1: With opcode 0x05, U=0 and size=0, each byte of the result holds the number of set bits of the matching source byte, as a value 0..8 in bits [3:0] with bits [7:4] zero.
- R2: With opcode 0x05, U=1 and size=0, the result is the bitwise complement of the source.
- R3: With opcode 0x05, U=1 and size=1, result bit 8k+j equals source bit 8k+7-j for every byte k, so byte order is unchanged.
- R4: With opcode 0x05 and any other U/size pairing (U=0 with size 1, 2 or 3; U=1 with size 2 or 3), out_undef is raised, out_valid stays low and out_result keeps its previous value.
- R5: Any opcode other than 0x05 raises out_undef, holds out_result and keeps out_valid low.
- R6: With in_q=0, result bits [63:0] carry the operation on source bits [63:0] and bits [127:64] are zero. With in_q=1, all 128 bits are produced.
- R7: The outputs follow a strobed request at the next rising clock edge. A cycle without in_valid leaves both flags low at the following edge and the result unchanged.
- R8: out_valid and out_undef are never high together.
- R9: While rst_n is low, out_valid and out_undef are low and out_result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_q | input | 1 | 1: 128-bit operation, 0: lower 64 bits only |
| in_u | input | 1 | U qualifier of the encoding |
| in_size | input | 2 | Size field, used as part of the operation selector |
| in_opcode | input | 5 | Opcode field |
| in_src | input | 128 | Source vector |
| out_valid | output | 1 | Registered result is valid |
| out_undef | output | 1 | Registered undefined-encoding flag |
| out_result | output | 128 | Registered result vector |

## Verification
Every opcode value is combined with all U/size pairs and both widths, and each combination is applied to all-zero, all-one, single-bit and alternating vectors. This sweep separates the three allocated selectors from the five unallocated ones and from foreign opcodes. All-ones and single-bit bytes expose a count that saturates or misses the 8 value. Asymmetric byte patterns catch a reversal that swaps bytes or nibbles in the wrong way. Random vectors then compare each operation at both widths against a bit-by-bit model, and idle cycles between requests show that the held result survives undefined encodings.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

   localparam int SIZE_W = 2;

   typedef enum logic [1:0] {
      BMU_CNT  = 2'd0,
      BMU_NOT  = 2'd1,
      BMU_RBIT = 2'd2,
      BMU_UND  = 2'd3
   } bmu_op_e;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
   import bmu_pkg::*;
#(
   parameter int                 OPC_W     = 5,
   parameter logic [OPC_W-1:0]   GROUP_OPC = 'h5
) (
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic              u_i,
   input  logic [SIZE_W-1:0] size_i,
   output bmu_op_e           op_o
);

   always_comb begin
      op_o = BMU_UND;
      if (opcode_i == GROUP_OPC) begin
         case ({u_i, size_i})
            3'b000:  op_o = BMU_CNT;
            3'b100:  op_o = BMU_NOT;
            3'b101:  op_o = BMU_RBIT;
            default: op_o = BMU_UND;
         endcase
      end
   end

endmodule

// File: rtl/bmu_lane.sv
module bmu_lane #(
   parameter int LANE_W   = 8,
   parameter bit MASK_REV = 1'b1
) (
   input  logic [LANE_W-1:0] lane_i,
   output logic [LANE_W-1:0] cnt_o,
   output logic [LANE_W-1:0] rev_o
);

   localparam int CNT_W = $clog2(LANE_W + 1);

   if (CNT_W > LANE_W) begin : g_bad_cnt
      $error("bmu_lane: count does not fit in a lane");
   end

   logic [CNT_W-1:0] ones;

   always_comb begin
      ones = '0;
      for (int b = 0; b < LANE_W; b++) begin
         ones = ones + CNT_W'(lane_i[b]);
      end
   end

   assign cnt_o = LANE_W'(ones);

   if (MASK_REV && (LANE_W == 8)) begin : g_mask_rev
      logic [7:0] swapped;
      assign swapped = {lane_i[3:0], lane_i[7:4]};
      assign rev_o   = ((swapped & 8'h88) >> 3) |
                       ((swapped & 8'h44) >> 1) |
                       ((swapped & 8'h22) << 1) |
                       ((swapped & 8'h11) << 3);
   end else begin : g_wire_rev
      for (genvar b = 0; b < LANE_W; b++) begin : g_bit
         assign rev_o[b] = lane_i[LANE_W-1-b];
      end
   end

endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
   import bmu_pkg::*;
#(
   parameter int VEC_W    = 128,
   parameter int LANE_W   = 8,
   parameter bit MASK_REV = 1'b1
) (
   input  bmu_op_e          op_i,
   input  logic             q_i,
   input  logic [VEC_W-1:0] src_i,
   output logic [VEC_W-1:0] res_o
);

   localparam int NLANE = VEC_W / LANE_W;
   localparam int HALF  = VEC_W / 2;

   if ((VEC_W % 2) != 0 || (HALF % LANE_W) != 0) begin : g_bad_geom
      $error("bmu_datapath: half vector must hold whole lanes");
   end

   logic [VEC_W-1:0] cnt_v;
   logic [VEC_W-1:0] rev_v;
   logic [VEC_W-1:0] raw;

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      bmu_lane #(
         .LANE_W   (LANE_W),
         .MASK_REV (MASK_REV)
      ) lane_i (
         .lane_i (src_i[l*LANE_W +: LANE_W]),
         .cnt_o  (cnt_v[l*LANE_W +: LANE_W]),
         .rev_o  (rev_v[l*LANE_W +: LANE_W])
      );
   end

   always_comb begin
      case (op_i)
         BMU_CNT:  raw = cnt_v;
         BMU_NOT:  raw = ~src_i;
         BMU_RBIT: raw = rev_v;
         default:  raw = '0;
      endcase
   end

   assign res_o = q_i ? raw : {{(VEC_W-HALF){1'b0}}, raw[HALF-1:0]};

endmodule

// File: rtl/simd_bytemisc_unit.sv
module simd_bytemisc_unit
   import bmu_pkg::*;
#(
   parameter int               VEC_W     = 128,
   parameter int               LANE_W    = 8,
   parameter int               OPC_W     = 5,
   parameter logic [OPC_W-1:0] GROUP_OPC = 'h5,
   parameter bit               MASK_REV  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_q,
   input  logic              in_u,
   input  logic [SIZE_W-1:0] in_size,
   input  logic [OPC_W-1:0]  in_opcode,
   input  logic [VEC_W-1:0]  in_src,
   output logic              out_valid,
   output logic              out_undef,
   output logic [VEC_W-1:0]  out_result
);

   if ((VEC_W % LANE_W) != 0 || LANE_W < 2) begin : g_bad_lane
      $error("simd_bytemisc_unit: vector must split into lanes of 2+ bits");
   end

   bmu_op_e          op;
   logic [VEC_W-1:0] res;
   logic             take;

   bmu_decode #(
      .OPC_W     (OPC_W),
      .GROUP_OPC (GROUP_OPC)
   ) dec_i (
      .opcode_i (in_opcode),
      .u_i      (in_u),
      .size_i   (in_size),
      .op_o     (op)
   );

   bmu_datapath #(
      .VEC_W    (VEC_W),
      .LANE_W   (LANE_W),
      .MASK_REV (MASK_REV)
   ) dp_i (
      .op_i  (op),
      .q_i   (in_q),
      .src_i (in_src),
      .res_o (res)
   );

   assign take = in_valid && (op != BMU_UND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_undef  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= take;
         out_undef <= in_valid && (op == BMU_UND);
         if (take) begin
            out_result <= res;
         end
      end
   end

endmodule

// File: rtl/bmu_chk.sv
module bmu_chk
   import bmu_pkg::*;
#(
   parameter int               VEC_W     = 128,
   parameter int               LANE_W    = 8,
   parameter int               OPC_W     = 5,
   parameter logic [OPC_W-1:0] GROUP_OPC = 'h5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_q,
   input logic              in_u,
   input logic [SIZE_W-1:0] in_size,
   input logic [OPC_W-1:0]  in_opcode,
   input logic [VEC_W-1:0]  in_src,
   input logic              out_valid,
   input logic              out_undef,
   input logic [VEC_W-1:0]  out_result
);

   localparam int CNT_W = $clog2(LANE_W + 1);
   localparam int HALF  = VEC_W / 2;

   logic past_ok;
   logic cnt_req;
   logic cnt_hi_zero;
   logic src_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign cnt_req = in_valid && (in_opcode == GROUP_OPC) && !in_u && (in_size == '0);
   assign src_any = |in_src;

   always_comb begin
      cnt_hi_zero = 1'b1;
      for (int b = 0; b < VEC_W; b++) begin
         if (((b % LANE_W) >= CNT_W) && out_result[b]) cnt_hi_zero = 1'b0;
      end
   end

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_undef)); // R8

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((out_valid || out_undef) == $past(in_valid))); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(in_valid)) |-> $stable(out_result)); // R7

   AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && out_undef) |-> $stable(out_result)); // R4

   AST_FOREIGN_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(in_valid) && ($past(in_opcode) != GROUP_OPC)) |-> out_undef); // R5

   AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && out_valid && !$past(in_q)) |-> (out_result[VEC_W-1:HALF] == '0)); // R6

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && out_valid && $past(cnt_req)) |-> cnt_hi_zero); // R1

   AST_RESET_QUIET: assert property (@(posedge clk)
      (!rst_n) |-> (!out_valid && !out_undef && (out_result == '0) && (src_any || !src_any))); // R9

endmodule

bind simd_bytemisc_unit bmu_chk #(
   .VEC_W     (VEC_W),
   .LANE_W    (LANE_W),
   .OPC_W     (OPC_W),
   .GROUP_OPC (GROUP_OPC)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_q       (in_q),
   .in_u       (in_u),
   .in_size    (in_size),
   .in_opcode  (in_opcode),
   .in_src     (in_src),
   .out_valid  (out_valid),
   .out_undef  (out_undef),
   .out_result (out_result)
);

// File: tb/simd_bytemisc_unit_tb_top.sv
`timescale 1ns/1ps
module simd_bytemisc_unit_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_q = 1'b0;
   logic         in_u = 1'b0;
   logic [1:0]   in_size = '0;
   logic [4:0]   in_opcode = '0;
   logic [127:0] in_src = '0;
   logic         out_valid;
   logic         out_undef;
   logic [127:0] out_result;

   int total = 0;
   int bad   = 0;
   logic [127:0] held = '0;

   always #2 clk = ~clk;

   simd_bytemisc_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_q       (in_q),
      .in_u       (in_u),
      .in_size    (in_size),
      .in_opcode  (in_opcode),
      .in_src     (in_src),
      .out_valid  (out_valid),
      .out_undef  (out_undef),
      .out_result (out_result)
   );

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // 0: count, 1: complement, 2: reverse, 3: undefined
   function automatic int classify(input logic [4:0] opc, input logic u, input logic [1:0] sz);
      if (opc != 5'h05)          return 3;
      if (!u && sz == 2'd0)      return 0;
      if (u && sz == 2'd0)       return 1;
      if (u && sz == 2'd1)       return 2;
      return 3;
   endfunction

   function automatic logic [127:0] model(input int kind, input logic q, input logic [127:0] s);
      logic [127:0] r;
      r = '0;
      for (int k = 0; k < 16; k++) begin
         int n;
         n = 0;
         for (int j = 0; j < 8; j++) begin
            n += int'(s[8*k+j]);
            if (kind == 1) r[8*k+j] = ~s[8*k+j];
            if (kind == 2) r[8*k+j] = s[8*k+7-j];
         end
         if (kind == 0) r[8*k +: 8] = 8'(n);
      end
      if (!q) r[127:64] = '0;
      return r;
   endfunction

   task automatic issue(input logic [4:0] opc, input logic u, input logic [1:0] sz,
                        input logic q, input logic [127:0] s);
      int kind;
      string req;
      logic [127:0] exp;
      kind = classify(opc, u, sz);
      @(negedge clk);
      in_valid = 1'b1; in_opcode = opc; in_u = u; in_size = sz; in_q = q; in_src = s;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      check(!(out_valid && out_undef), "R8", {126'd0, out_valid, out_undef}, 128'd0);
      if (kind == 3) begin
         req = (opc == 5'h05) ? "R4" : "R5";
         check(out_undef && !out_valid, req, {126'd0, out_valid, out_undef}, 128'd1);
         check(out_result == held, req, out_result, held);
      end else begin
         exp = model(kind, q, s);
         req = (kind == 0) ? "R1" : (kind == 1) ? "R2" : "R3";
         check(out_valid && !out_undef, "R7", {126'd0, out_valid, out_undef}, 128'd2);
         check(out_result == exp, req, out_result, exp);
         if (!q) check(out_result[127:64] == '0, "R6", out_result, exp);
         held = exp;
      end
   endtask

   task automatic idle_check();
      @(negedge clk);
      in_valid = 1'b0;
      in_opcode = 5'h05; in_u = 1'b0; in_size = '0; in_src = '1;
      @(posedge clk);
      #1;
      check(!out_valid && !out_undef, "R7", {126'd0, out_valid, out_undef}, 128'd0);
      check(out_result == held, "R7", out_result, held);
   endtask

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL R7 watchdog act=hang exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [127:0] pats [6];
      pats[0] = '0;
      pats[1] = '1;
      pats[2] = {16{8'h01}};
      pats[3] = {8{16'hA5_3C}};
      pats[4] = 128'h80402010_08040201_F0E1D2C3_B4A59687;
      pats[5] = 128'h0123456789ABCDEF_FEDCBA9876543210;

      repeat (3) @(posedge clk);
      #1;
      check(!out_valid && !out_undef && out_result == '0, "R9",
            out_result, 128'd0);
      @(negedge clk);
      rst_n = 1'b1;
      idle_check();

      for (int opc = 0; opc < 32; opc++) begin
         for (int us = 0; us < 8; us++) begin
            for (int q = 0; q < 2; q++) begin
               for (int p = 0; p < 6; p++) begin
                  issue(5'(opc), us[2], us[1:0], q[0], pats[p]);
               end
            end
            idle_check();
         end
      end

      for (int i = 0; i < 600; i++) begin
         logic [127:0] v;
         v = {$urandom, $urandom, $urandom, $urandom};
         case (i % 3)
            0: issue(5'h05, 1'b0, 2'd0, i[3], v);
            1: issue(5'h05, 1'b1, 2'd0, i[3], v);
            default: issue(5'h05, 1'b1, 2'd1, i[3], v);
         endcase
         if ((i % 7) == 0) issue(5'h05, 1'b0, 2'(1 + i % 3), i[2], v);
         if ((i % 11) == 0) idle_check();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule